// File: doc/BRIEF.md
# PHY Management Serial Master

This block is a management-bus master that carries out exactly one Clause 22 access to an external PHY for each command that software issues. Software loads a 32-bit data register and then writes a command word. The command word holds a go flag, a read or write select, a 5-bit PHY address and a 5-bit register address. The block builds the 64-bit management frame and shifts it out on MDC/MDIO. It drops the go flag when the last bit has been clocked.

For a read, the PHY drives the bus after the turnaround. The 16 returned bits land in the upper half of the data register. A status flag records whether the PHY took the bus in the second turnaround bit. MDC is a divided copy of the system clock and runs only while a frame is in flight. MDIO changes on MDC falling edges and is sampled on MDC rising edges.

Top module: `phy_mgmt_master`

## Requirements
- R1: After reset the command readback, the data readback and the status flag are all 0, MDC is low and the MDIO output enable is low. Whenever the block is idle, MDC stays low and the output enable stays low.
- R2: A command write (wr_sel = 0) with bit 20 set and exactly one of bit 17 (read) or bit 16 (write) set is accepted while idle. Readback bit 20 is 1 from the next cycle on and drops to 0 after exactly 128 × DIV_HALF system cycles.
- R3: A write sends this frame MSB first: 32 ones, 01, opcode 01, PHY address (command bits 12:8), register address (command bits 4:0), 10, then data register bits 15:0. The output enable is high for all 64 bits.
- R4: A read sends 32 ones, 01, opcode 10, the PHY address and the register address with the output enable high. It then releases the bus (output enable low) for the final 18 bit times.
- R5: On a read, the 16 bits sampled on the last 16 MDC rising edges, first bit as MSB, are written to data bits 31:16. Data bits 15:0 keep their value. Status bit 0 becomes 0 when the PHY drove the second turnaround bit low.
- R6: If the PHY leaves the second turnaround bit high, status bit 0 becomes 1 at the end of that read. The status changes only at the end of a read.
- R7: While a frame is in flight, command writes and data writes are ignored. The frame on the wire, the command fields and the data register are unchanged, and no extra frame follows.
- R8: A command write without bit 20, or with both or neither of bits 17 and 16, starts nothing. Busy stays 0 and MDC stays low. The op, PHY and register fields are still stored and read back.
- R9: During a frame MDC has a period of 2 × DIV_HALF system cycles and is high for 64 × DIV_HALF cycles in total. MDIO output changes only in the cycle where MDC falls.
- R10: A write frame leaves the status flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 command, 1 data |
| wr_data | input | 32 | Register write value |
| cmd_rd | output | 32 | Command readback; bit 20 is busy |
| data_rd | output | 32 | Data register readback |
| status_rd | output | 1 | 1 when the last read was invalid |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench models a PHY that captures every bit on MDC rising edges and answers reads with chosen data and a chosen turnaround level. It therefore catches a frame that has an off-by-one field, a wrong opcode, a bus released one bit early or late, or read data that is shifted or lands in the wrong half. It issues commands and data writes in the middle of a frame. A design that latches them would corrupt the frame on the wire or start a second frame. It also sends malformed commands, which a careless decoder would start. It checks that the invalid-read flag sets on a missing turnaround, survives a following write frame and clears on a good read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_GO_BIT   = 20;
  localparam int CMD_RD_BIT   = 17;
  localparam int CMD_WR_BIT   = 16;
  localparam int PHY_LSB      = 8;
  localparam int REG_LSB      = 0;
  localparam int ADDR_W       = 5;
  localparam int FRAME_BITS   = 64;
  localparam int TA_FIRST     = 46;
  localparam int TA_LAST      = 47;
  localparam int DATA_FIRST   = 48;
  localparam int IDX_W        = $clog2(FRAME_BITS);

  typedef struct packed {
    logic              is_read;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
  } mdio_req_t;
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int DIV_HALF = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  always_comb begin
    tick  = en && (cnt_q == CW'(DIV_HALF - 1));
    cnt_d = '0;
    mdc_d = 1'b0;
    if (en) begin
      cnt_d = tick ? '0 : cnt_q + 1'b1;
      mdc_d = tick ? ~mdc_q : mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc  = mdc_q;
  assign rise = tick & ~mdc_q;
  assign fall = tick & mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_req_t   req,
  input  logic [15:0] wdata,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic        done_read,
  output logic        rd_ok,
  output logic [15:0] rd_data
);
  logic                  busy_q, busy_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  rd_q, rd_d;
  logic                  ta_ok_q, ta_ok_d;
  logic [15:0]           cap_q, cap_d;
  logic                  last_bit;

  assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    rd_d    = rd_q;
    ta_ok_d = ta_ok_q;
    cap_d   = cap_q;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        idx_d   = '0;
        rd_d    = req.is_read;
        ta_ok_d = 1'b0;
        cap_d   = '0;
        sh_d    = {32'hFFFF_FFFF, 2'b01,
                   (req.is_read ? 2'b10 : 2'b01),
                   req.phy, req.regad,
                   (req.is_read ? 2'b11 : 2'b10),
                   (req.is_read ? 16'hFFFF : wdata)};
      end
    end else begin
      if (rise && rd_q) begin
        if (idx_q == IDX_W'(TA_LAST))
          ta_ok_d = ~mdio_i;
        if (idx_q >= IDX_W'(DATA_FIRST))
          cap_d = {cap_q[14:0], mdio_i};
      end
      if (fall) begin
        sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        idx_d = idx_q + 1'b1;
        if (last_bit)
          busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      sh_q    <= '1;
      rd_q    <= 1'b0;
      ta_ok_q <= 1'b0;
      cap_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      rd_q    <= rd_d;
      ta_ok_q <= ta_ok_d;
      cap_q   <= cap_d;
    end
  end

  assign busy      = busy_q;
  assign mdio_o    = busy_q ? sh_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe   = busy_q && !(rd_q && (idx_q >= IDX_W'(TA_FIRST)));
  assign done      = busy_q && fall && last_bit;
  assign done_read = rd_q;
  assign rd_ok     = ta_ok_q;
  assign rd_data   = cap_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        busy,
  input  logic        done,
  input  logic        done_read,
  input  logic        rd_ok,
  input  logic [15:0] rd_data,
  output logic        start,
  output mdio_req_t   req,
  output logic [15:0] wdata,
  output logic [31:0] cmd_rd,
  output logic [31:0] data_rd,
  output logic        status_rd
);
  logic              op_rd_q, op_rd_d;
  logic              op_wr_q, op_wr_d;
  logic [ADDR_W-1:0] phy_q, phy_d;
  logic [ADDR_W-1:0] reg_q, reg_d;
  logic [31:0]       data_q, data_d;
  logic              bad_q, bad_d;
  logic              cmd_take, data_take;

  always_comb begin
    cmd_take  = wr_en && !wr_sel && !busy;
    data_take = wr_en &&  wr_sel && !busy;
    start     = cmd_take && wr_data[CMD_GO_BIT] &&
                (wr_data[CMD_RD_BIT] ^ wr_data[CMD_WR_BIT]);

    op_rd_d = op_rd_q;
    op_wr_d = op_wr_q;
    phy_d   = phy_q;
    reg_d   = reg_q;
    if (cmd_take) begin
      op_rd_d = wr_data[CMD_RD_BIT];
      op_wr_d = wr_data[CMD_WR_BIT];
      phy_d   = wr_data[PHY_LSB +: ADDR_W];
      reg_d   = wr_data[REG_LSB +: ADDR_W];
    end

    data_d = data_q;
    bad_d  = bad_q;
    if (done && done_read) begin
      data_d[31:16] = rd_data;
      bad_d         = ~rd_ok;
    end else if (data_take) begin
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_rd_q <= 1'b0;
      op_wr_q <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      data_q  <= '0;
      bad_q   <= 1'b0;
    end else begin
      op_rd_q <= op_rd_d;
      op_wr_q <= op_wr_d;
      phy_q   <= phy_d;
      reg_q   <= reg_d;
      data_q  <= data_d;
      bad_q   <= bad_d;
    end
  end

  always_comb begin
    cmd_rd                        = '0;
    cmd_rd[CMD_GO_BIT]            = busy;
    cmd_rd[CMD_RD_BIT]            = op_rd_q;
    cmd_rd[CMD_WR_BIT]            = op_wr_q;
    cmd_rd[PHY_LSB +: ADDR_W]     = phy_q;
    cmd_rd[REG_LSB +: ADDR_W]     = reg_q;
  end

  assign req       = '{is_read: wr_data[CMD_RD_BIT],
                       phy:     wr_data[PHY_LSB +: ADDR_W],
                       regad:   wr_data[REG_LSB +: ADDR_W]};
  assign wdata     = data_q[15:0];
  assign data_rd   = data_q;
  assign status_rd = bad_q;
endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] cmd_rd,
  output logic [31:0] data_rd,
  output logic        status_rd,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        rst_meta_q, rst_sync_q;
  logic        busy, start, done, done_read, rd_ok, rise, fall;
  mdio_req_t   req;
  logic [15:0] wdata, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mdc_divider #(.DIV_HALF(DIV_HALF)) i_div (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .en    (busy),
    .mdc   (mdc),
    .rise  (rise),
    .fall  (fall)
  );

  mdio_frame_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start     (start),
    .req       (req),
    .wdata     (wdata),
    .rise      (rise),
    .fall      (fall),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .done_read (done_read),
    .rd_ok     (rd_ok),
    .rd_data   (rd_data)
  );

  mdio_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .busy      (busy),
    .done      (done),
    .done_read (done_read),
    .rd_ok     (rd_ok),
    .rd_data   (rd_data),
    .start     (start),
    .req       (req),
    .wdata     (wdata),
    .cmd_rd    (cmd_rd),
    .data_rd   (data_rd),
    .status_rd (status_rd)
  );
endmodule

// File: rtl/phy_mgmt_master_chk.sv
module phy_mgmt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [31:0] wr_data,
  input logic [31:0] cmd_rd,
  input logic [31:0] data_rd,
  input logic        status_rd,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        mdio_i
);
  logic unused_in;
  assign unused_in = mdio_i;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rd[20] |-> (!mdc && !mdio_oe));

  assert_go_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_rd[20]) |-> $past(wr_en && !wr_sel && wr_data[20]));

  assert_status_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_rd) |-> $fell(cmd_rd[20]));

  assert_fields_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd[20] && $past(cmd_rd[20])) |-> $stable(cmd_rd[17:0]));

  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd[20] && $past(cmd_rd[20])) |-> $stable(data_rd));

  assert_mdo_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd[20] && $past(cmd_rd[20]) && !$stable(mdio_o)) |-> $fell(mdc));
endmodule

bind phy_mgmt_master phy_mgmt_master_chk i_chk (.*);

// File: tb/test_phy_mgmt_master.sv
module test_phy_mgmt_master;
  localparam int H = 4;
  localparam int FRAME_CYC = 128 * H;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_sel;
  logic [31:0] wr_data;
  logic [31:0] cmd_rd, data_rd;
  logic        status_rd, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int          checks = 0;
  int          errors = 0;
  int          rise_n = 0;
  int          base   = 0;
  logic [63:0] cap_o  = '0;
  logic [63:0] cap_oe = '0;
  logic        resp_ta_good = 1'b1;
  logic [15:0] resp_data = '0;

  always #2.5 clk = ~clk;

  phy_mgmt_master #(.DIV_HALF(H)) i_phy_mgmt_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_rd(cmd_rd), .data_rd(data_rd), .status_rd(status_rd),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: capture on MDC rise, answer after MDC fall
  always @(posedge mdc) begin
    cap_o  = {cap_o[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    rise_n = rise_n + 1;
  end

  always @(negedge mdc) begin
    int k;
    k = rise_n - base;
    if (k == 47)                 mdio_i = resp_ta_good ? 1'b0 : 1'b1;
    else if (k >= 48 && k <= 63) mdio_i = resp_data[63 - k];
    else                         mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(bit go, bit rd, bit wr,
                                         logic [4:0] phy, logic [4:0] rg);
    logic [31:0] c;
    c = '0;
    c[20] = go; c[17] = rd; c[16] = wr;
    c[12:8] = phy; c[4:0] = rg;
    return c;
  endfunction

  task automatic put(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int cyc, output int hi);
    cyc = 0; hi = 0;
    while (cmd_rd[20] && cyc < 5000) begin
      if (mdc) hi++;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset;
    chk(cmd_rd == 32'h0, "R1 cmd after reset", cmd_rd, 0);
    chk(data_rd == 32'h0, "R1 data after reset", data_rd, 0);
    chk(status_rd == 1'b0, "R1 status after reset", status_rd, 0);
    chk(!mdc && !mdio_oe, "R1 bus idle after reset", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d);
    int cyc, hi;
    logic [63:0] exp;
    bit st0;
    st0 = status_rd;
    put(1'b1, {16'h0, d});
    base = rise_n;
    put(1'b0, mk_cmd(1, 0, 1, phy, rg));
    chk(cmd_rd[20] == 1'b1, "R2 busy after write cmd", cmd_rd[20], 1);
    wait_idle(cyc, hi);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
    chk(cyc == FRAME_CYC, "R2 busy length", cyc, FRAME_CYC);
    chk(hi == 64 * H, "R9 mdc high time", hi, 64 * H);
    chk(cap_o == exp, "R3 write frame", cap_o, exp);
    chk(cap_oe == '1, "R3 write drives all bits", cap_oe, '1);
    chk(cmd_rd == mk_cmd(0, 0, 1, phy, rg), "R2 cmd readback idle", cmd_rd,
        mk_cmd(0, 0, 1, phy, rg));
    chk(status_rd == st0, "R10 write keeps status", status_rd, st0);
    chk(data_rd == {16'h0, d}, "R3 data kept after write", data_rd, {16'h0, d});
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] resp, input bit ta_good,
                       input logic [31:0] pre);
    int cyc, hi;
    logic [45:0] exp_hdr;
    put(1'b1, pre);
    resp_data = resp;
    resp_ta_good = ta_good;
    base = rise_n;
    put(1'b0, mk_cmd(1, 1, 0, phy, rg));
    wait_idle(cyc, hi);
    exp_hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg};
    chk(cyc == FRAME_CYC, "R2 read busy length", cyc, FRAME_CYC);
    chk(cap_o[63:18] == exp_hdr, "R4 read header", cap_o[63:18], exp_hdr);
    chk(cap_oe == {{46{1'b1}}, 18'h0}, "R4 read bus release", cap_oe,
        {{46{1'b1}}, 18'h0});
    chk(data_rd == {resp, pre[15:0]}, ta_good ? "R5 read data" : "R6 read data",
        data_rd, {resp, pre[15:0]});
    chk(status_rd == !ta_good, ta_good ? "R5 status good" : "R6 status bad",
        status_rd, !ta_good);
  endtask

  task automatic t_busy_ignore;
    int cyc, hi;
    logic [63:0] exp;
    put(1'b1, 32'h0000_3C5A);
    base = rise_n;
    put(1'b0, mk_cmd(1, 0, 1, 5'h07, 5'h11));
    repeat (30) @(negedge clk);
    put(1'b0, mk_cmd(1, 1, 0, 5'h1E, 5'h02));
    put(1'b1, 32'hFFFF_0000);
    chk(cmd_rd == mk_cmd(1, 0, 1, 5'h07, 5'h11), "R7 cmd fields held",
        cmd_rd, mk_cmd(1, 0, 1, 5'h07, 5'h11));
    wait_idle(cyc, hi);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h07, 5'h11, 2'b10, 16'h3C5A};
    chk(cap_o == exp, "R7 frame unchanged", cap_o, exp);
    chk(data_rd == 32'h0000_3C5A, "R7 data write ignored", data_rd, 32'h3C5A);
    repeat (40) @(negedge clk);
    chk(cmd_rd[20] == 1'b0 && !mdc, "R7 no extra frame", {cmd_rd[20], mdc}, 0);
  endtask

  task automatic t_bad_cmd(input bit go, input bit rd, input bit wr);
    logic [31:0] c;
    c = mk_cmd(go, rd, wr, 5'h15, 5'h0A);
    put(1'b0, c);
    repeat (3 * H) @(negedge clk);
    chk(cmd_rd[20] == 1'b0 && !mdc && !mdio_oe, "R8 no frame started",
        {cmd_rd[20], mdc, mdio_oe}, 0);
    chk(cmd_rd == mk_cmd(0, rd, wr, 5'h15, 5'h0A), "R8 fields stored", cmd_rd,
        mk_cmd(0, rd, wr, 5'h15, 5'h0A));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write(5'h13, 5'h0A, 16'hA5C3);
    t_read(5'h01, 5'h02, 16'h1234, 1'b1, 32'h5555_BEEF);
    t_read(5'h1F, 5'h1F, 16'h0F0F, 1'b0, 32'h0000_00AA);
    t_write(5'h00, 5'h1F, 16'h8001);
    t_read(5'h0C, 5'h05, 16'hC0DE, 1'b1, 32'h1111_2222);
    t_busy_ignore();
    t_bad_cmd(1'b0, 1'b0, 1'b1);
    t_bad_cmd(1'b1, 1'b1, 1'b1);
    t_bad_cmd(1'b1, 1'b0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule